// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time-of-Day Counter

This block keeps a free-running 64-bit count of whole nanoseconds for precision time stamping. The count has no seconds field and wraps at 2^64. On every enabled clock cycle it adds a fixed-point step with a 32-bit fraction. A 32-bit fraction accumulator collects the fractional part of the step, and its carry adds one extra nanosecond. Software picks the step to match the period of the clock that drives the block. Examples are 1.6 ns (step 0x0199999999), 3.2 ns (0x0333333333) and 32 ns (0x2000000000). Software trims the step by parts per billion to steer the frequency. A step of zero freezes the count.

All access goes through a 32-bit register port. The time and the step are 64 bits wide, so each is written as two words. The low word waits in a holding register, and the value takes effect only when the high word is written. A read of the low time word captures the upper half of the count, so the high-word read that follows belongs to the same instant. Software applies a time offset by reading the time, adding the offset and writing the result back. The current count is also driven on a wide output for timestamp capture logic.

Top module: `ptp_ns_clock`

## Requirements
- R1: After reset the count is 0, the fraction accumulator is 0, counting is off, the active step reads back as 0x0199999999 (high word 0x1, low word 0x99999999) and read data is 0.
- R2: Register address 0 is control, and bit 0 of it enables counting. The count changes only on clock edges where that enable is set, or when the time high word is written. A control write takes effect from the next edge.
- R3: On each enabled edge, the integer part of the step (bits 63:32) plus the carry out of the fraction accumulator is added to the count, and the fraction (bits 31:0) is added to the accumulator. So N edges after a time load, the count equals the loaded value plus floor(N*step/2^32). At the 1.6 ns step, the five edges that follow the first one advance the count by 8.
- R4: Reading address 1 (time low) returns the low 32 bits of the count and captures the upper 32 bits. Reading address 2 (time high) returns the captured upper bits, even if the count has changed since then.
- R5: Writing address 1 only loads a holding register and leaves the count unchanged. Writing address 2 loads the count with {written word, held low word} and clears the fraction accumulator.
- R6: Writing address 3 (step low) only loads a holding register. Writing address 4 (step high) makes {written word, held low word} the active step. Reading addresses 3 and 4 returns the low and high words of the active step.
- R7: While the active step is zero, the count does not change even with counting enabled.
- R8: The count wraps modulo 2^64.
- R9: Read data is registered: it shows the addressed value as it stood at the read edge, from the cycle after the read strobe. The time output shows the count directly.
- R10: A time high write on an edge where counting is enabled loads the written value exactly, with no step added on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one step per enabled edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address: 0 control, 1 time low, 2 time high, 3 step low, 4 step high |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| timeNow | output | 64 | Current nanosecond count |

## Verification
The hardest case to reach is the residue left in the fraction accumulator. No register exposes it, so it shows only as an off-by-one nanosecond after some later run of edges. The stimulus reaches it by running an exact number of edges: a control write turns counting on, and another turns it off a counted number of cycles later. A time reload is placed between runs that leave a non-zero fraction, and the count read afterwards is compared with floor(N*step/2^32). Random steps and random run lengths cover the carry at many accumulator values.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_TIME_LO = 3'd1,
    SEL_TIME_HI = 3'd2,
    SEL_INC_LO  = 3'd3,
    SEL_INC_HI  = 3'd4
  } regSel_e;

  // strobes from the register control to the counter datapath
  typedef struct packed {
    logic timeLoWr;
    logic timeHiWr;
    logic incLoWr;
    logic incHiWr;
    logic latchHi;
    logic count;
  } dpStb_t;

endpackage

// File: rtl/ptp_clk_dp.sv
module ptp_clk_dp
  import ptp_clk_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int FRAC_W = 32,
  parameter logic [2*REG_W-1:0] RESET_INC = 64'h0000_0001_9999_9999
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStb_t             stb,
  input  logic [REG_W-1:0]   wdata,
  output logic [2*REG_W-1:0] timeVal,
  output logic [2*REG_W-1:0] incVal,
  output logic [REG_W-1:0]   latchedHi
);
  localparam int TIME_W = 2 * REG_W;
  localparam int INC_W  = 2 * REG_W;
  localparam int INT_W  = INC_W - FRAC_W;

  logic [TIME_W-1:0] timeReg;
  logic [INC_W-1:0]  incReg;
  logic [FRAC_W-1:0] fracAcc;
  logic [REG_W-1:0]  timeHold;
  logic [REG_W-1:0]  incHold;
  logic [REG_W-1:0]  hiCapture;
  logic [FRAC_W:0]   fracSum;
  logic [TIME_W-1:0] timeNext;

  always_comb begin
    fracSum  = {1'b0, fracAcc} + {1'b0, incReg[FRAC_W-1:0]};
    timeNext = timeReg + TIME_W'(incReg[INC_W-1:INC_W-INT_W])
                       + TIME_W'(fracSum[FRAC_W]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeReg   <= '0;
      fracAcc   <= '0;
      incReg    <= RESET_INC;
      timeHold  <= '0;
      incHold   <= '0;
      hiCapture <= '0;
    end else begin
      if (stb.timeLoWr) timeHold <= wdata;
      if (stb.incLoWr)  incHold  <= wdata;
      if (stb.incHiWr)  incReg   <= {wdata, incHold};
      if (stb.latchHi)  hiCapture <= timeReg[TIME_W-1:REG_W];
      if (stb.timeHiWr) begin
        timeReg <= {wdata, timeHold};
        fracAcc <= '0;
      end else if (stb.count) begin
        timeReg <= timeNext;
        fracAcc <= fracSum[FRAC_W-1:0];
      end
    end
  end

  assign timeVal   = timeReg;
  assign incVal    = incReg;
  assign latchedHi = hiCapture;

endmodule

// File: rtl/ptp_clk_ctrl.sv
module ptp_clk_ctrl
  import ptp_clk_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [2:0]         regAddr,
  input  logic [REG_W-1:0]   regWdata,
  input  logic [2*REG_W-1:0] timeVal,
  input  logic [2*REG_W-1:0] incVal,
  input  logic [REG_W-1:0]   latchedHi,
  output dpStb_t             stb,
  output logic               countEn,
  output logic [REG_W-1:0]   rdata
);
  regSel_e sel;
  logic    enReg;

  assign sel = regSel_e'(regAddr);

  always_comb begin
    stb          = '0;
    stb.timeLoWr = regWr && (sel == SEL_TIME_LO);
    stb.timeHiWr = regWr && (sel == SEL_TIME_HI);
    stb.incLoWr  = regWr && (sel == SEL_INC_LO);
    stb.incHiWr  = regWr && (sel == SEL_INC_HI);
    stb.latchHi  = regRd && (sel == SEL_TIME_LO);
    stb.count    = enReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= 1'b0;
      rdata <= '0;
    end else begin
      if (regWr && (sel == SEL_CTRL)) enReg <= regWdata[0];
      if (regRd) begin
        case (sel)
          SEL_CTRL:    rdata <= REG_W'(enReg);
          SEL_TIME_LO: rdata <= timeVal[REG_W-1:0];
          SEL_TIME_HI: rdata <= latchedHi;
          SEL_INC_LO:  rdata <= incVal[REG_W-1:0];
          SEL_INC_HI:  rdata <= incVal[2*REG_W-1:REG_W];
          default:     rdata <= '0;
        endcase
      end
    end
  end

  assign countEn = enReg;

endmodule

// File: rtl/ptp_ns_clock.sv
module ptp_ns_clock
  import ptp_clk_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int FRAC_W = 32,
  parameter logic [2*REG_W-1:0] RESET_INC = 64'h0000_0001_9999_9999
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [2:0]         regAddr,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  output logic [2*REG_W-1:0] timeNow
);
  dpStb_t             stb;
  logic               countEn;
  logic [2*REG_W-1:0] incVal;
  logic [REG_W-1:0]   latchedHi;

  ptp_clk_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .timeVal(timeNow),
    .incVal(incVal), .latchedHi(latchedHi), .stb(stb),
    .countEn(countEn), .rdata(regRdata)
  );

  ptp_clk_dp #(.REG_W(REG_W), .FRAC_W(FRAC_W), .RESET_INC(RESET_INC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(regWdata),
    .timeVal(timeNow), .incVal(incVal), .latchedHi(latchedHi)
  );

endmodule

// File: rtl/ptp_clk_chk.sv
module ptp_clk_chk #(
  parameter int REG_W = 32,
  parameter int FRAC_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWr,
  input logic               regRd,
  input logic [2:0]         regAddr,
  input logic [REG_W-1:0]   regWdata,
  input logic [REG_W-1:0]   regRdata,
  input logic [2*REG_W-1:0] timeNow,
  input logic [2*REG_W-1:0] incVal,
  input logic               countEn
);
  localparam int TIME_W = 2 * REG_W;
  localparam int INT_W  = TIME_W - FRAC_W;

  logic              hiWr;
  logic [TIME_W-1:0] intStep;
  assign hiWr    = regWr && (regAddr == 3'd2);
  assign intStep = TIME_W'(incVal[TIME_W-1:TIME_W-INT_W]);

  assert_hi_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    hiWr |=> timeNow[TIME_W-1:REG_W] == $past(regWdata));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !hiWr) |=> timeNow == $past(timeNow));

  assert_step_size_R3: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !hiWr) |=> ((timeNow == $past(timeNow) + $past(intStep)) ||
                            (timeNow == $past(timeNow) + $past(intStep) + 1)));

  assert_zero_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (incVal == '0 && !hiWr) |=> $stable(timeNow));

  assert_lo_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 3'd1) |=> regRdata == $past(timeNow[REG_W-1:0]));

endmodule

bind ptp_ns_clock ptp_clk_chk #(.REG_W(REG_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .timeNow(timeNow),
  .incVal(incVal), .countEn(countEn)
);

// File: tb/sim_ptp_ns_clock.sv
module sim_ptp_ns_clock;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] INC_1G6 = 64'h0000_0001_9999_9999;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [63:0] timeNow;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [63:0] snap;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_ns_clock u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .timeNow(timeNow)
  );

  function automatic logic [63:0] model(logic [63:0] t0, logic [63:0] inc, int n);
    logic [127:0] prod;
    prod = 128'(inc) * 128'(n);
    return t0 + prod[95:32];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regRd = 1'b0; regAddr = a; regWdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      regWr = 1'b0; regRd = 1'b0;
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    snap = timeNow;
    regWr = 1'b0; regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic setTime(logic [63:0] t);
    wr(3'd1, t[31:0]); wr(3'd2, t[63:32]);
  endtask

  task automatic setInc(logic [63:0] v);
    wr(3'd3, v[31:0]); wr(3'd4, v[63:32]);
  endtask

  task automatic readTime(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(3'd1, lo); rd(3'd2, hi);
    t = {hi, lo};
  endtask

  task automatic run(int n);
    wr(3'd0, 32'd1); idle(n - 1); wr(3'd0, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] t, inc, t0;
    logic [31:0] d;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata", 64'(regRdata), 64'd0);
    check("R1 time", timeNow, 64'd0);
    rstN = 1'b1;
    rd(3'd3, d); check("R1 step lo", 64'(d), 64'h9999_9999);
    rd(3'd4, d); check("R1 step hi", 64'(d), 64'h1);
    rd(3'd0, d); check("R1 ctrl off", 64'(d), 64'd0);
    // R2: nothing moves while disabled
    idle(10);
    check("R2 disabled", timeNow, 64'd0);
    // R3: 1.6 ns step, first edge then five more edges advance 8
    setTime(64'd0);
    run(1); readTime(t); check("R3 one edge", t, model(0, INC_1G6, 1));
    run(5); readTime(t); check("R3 five edges", t - 64'd1, 64'd8);
    // R5: time load clears the leftover fraction
    setTime(64'd100);
    run(5); readTime(t); check("R5 fraction cleared", t, model(100, INC_1G6, 5));
    // R5: low write alone is held
    wr(3'd1, 32'h0000_DEAD);
    readTime(t); check("R5 low held", t, 64'd107);
    wr(3'd2, 32'h12);
    readTime(t); check("R5 commit", t, 64'h12_0000_DEAD);
    // R4: high read returns the word captured at the low read
    rd(3'd1, d);
    setTime(64'h34_0000_0000);
    rd(3'd2, d); check("R4 captured hi", 64'(d), 64'h12);
    readTime(t); check("R4 new time", t, 64'h34_0000_0000);
    // R10 / R9: load while counting wins; registered read sees the loaded value
    wr(3'd0, 32'd1);
    setTime(64'h2_0000_0055);
    rd(3'd1, d);
    check("R10 load exact", snap, 64'h2_0000_0055);
    check("R9 registered read", 64'(d), 64'h55);
    wr(3'd0, 32'd0);
    readTime(t); check("R9 output matches", timeNow, t);
    // R6: step commit on high word only
    setInc(64'h20_0000_0000);
    rd(3'd4, d); check("R6 step hi", 64'(d), 64'h20);
    setTime(64'd0);
    wr(3'd3, 32'h8000_0000);
    run(3); readTime(t); check("R6 old step kept", t, 64'd96);
    rd(3'd3, d); check("R6 step lo unchanged", 64'(d), 64'd0);
    wr(3'd4, 32'h3);
    run(2); readTime(t); check("R6 new step", t, 64'd103);
    // R7: zero step freezes
    setInc(64'd0);
    run(20); readTime(t); check("R7 frozen", t, 64'd103);
    // R8: wrap
    setInc(64'h20_0000_0000);
    setTime(64'hFFFF_FFFF_FFFF_FFF0);
    run(1); readTime(t); check("R8 wrap", t, 64'h10);
    // R3: random steps and run lengths
    for (int k = 0; k < 24; k++) begin
      inc = {24'd0, 8'($urandom), 32'($urandom)};
      t0  = {32'($urandom), 32'($urandom)};
      n   = 1 + int'($urandom % 30);
      setInc(inc); setTime(t0);
      run(n); readTime(t);
      check("R3 random", t, model(t0, inc, n));
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule